// File: doc/BRIEF.md
# Asynchronous Static RAM Controller

This block sits between a clocked system and an external asynchronous static RAM of 512K sixteen-bit words. It takes one read or one write per request, with a request/ready handshake. It then produces the chip-select, write-enable, output-enable and byte-enable pin sequences the memory needs. Every analog timing limit of the 70 ns speed grade is turned into a whole number of clock cycles from a clock-period parameter. Each count is the nanosecond figure divided by the period and rounded up, and never less than one.

The memory is selected only while its active-low chip select is low and its active-high chip select is high. Between accesses the controller deselects it and holds both write enable and output enable high. Reads hold output enable low for the longest access time, then sample the data bus and return it with a one-cycle valid strobe. Writes drive the data bus through a separate output-enable signal, and they do so only after the memory has had time to stop driving after a read. The write-enable pulse is held long enough to cover the data setup time. A byte mask selects the lanes: bit 0 enables bits 7:0 and bit 1 enables bits 15:8.

Top module: `sram_async_ctrl`

## Requirements
- R1: While idle, the controller drives mem_ce1_n=1, mem_ce2=0, mem_we_n=1, mem_oe_n=1, mem_ub_n=1, mem_lb_n=1 and mem_dq_oe=0. This also holds right after reset.
- R2: A read holds chip select, mem_oe_n low and mem_we_n high for max(ceil(70/P), ceil(35/P)) cycles, which is 7 at P=10 ns. The data bus is captured on the edge that ends the last of these cycles. rsp_valid is high for exactly one cycle: the 8th cycle after the accepting edge, carrying the captured word.
- R3: A write holds mem_we_n low for max(ceil(50/P), ceil(30/P)) cycles, which is 5 at P=10 ns. The written data is driven and unchanged for that whole pulse.
- R4: A write issued while the bus is settled keeps req_ready low for ceil(70/P) cycles, which is 7 at P=10 ns.
- R5: req_bmask bit 0 drives mem_lb_n low for bits 7:0, and bit 1 drives mem_ub_n low for bits 15:8. A masked-off lane keeps its stored value. A write with mask 00 changes nothing.
- R6: A read's rsp_rdata lanes whose mask bit is 0 return zero.
- R7: mem_dq_oe rises only after mem_oe_n has been high for at least ceil(25/P) full cycles, which is 3 at P=10 ns. A write accepted in the cycle a read completes therefore keeps req_ready low for 9 cycles.
- R8: mem_we_n and mem_oe_n are never low together. mem_dq_oe is high exactly while mem_we_n is low, so the bus is released in the cycle write enable returns high.
- R9: mem_addr, mem_dq_o, mem_ub_n and mem_lb_n do not change while mem_we_n is low.
- R10: req_ready is high only while idle, and a request is taken on a clock edge with req_valid and req_ready both high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller can take a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 19 | Word address |
| req_wdata | input | 16 | Write data |
| req_bmask | input | 2 | Lane enables, bit 0 = bits 7:0, bit 1 = bits 15:8 |
| rsp_rdata | output | 16 | Read data |
| rsp_valid | output | 1 | One-cycle read-data strobe |
| mem_ce1_n | output | 1 | Active-low chip select |
| mem_ce2 | output | 1 | Active-high chip select |
| mem_we_n | output | 1 | Write enable, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_ub_n | output | 1 | Upper byte enable, active low |
| mem_lb_n | output | 1 | Lower byte enable, active low |
| mem_addr | output | 19 | Memory address |
| mem_dq_o | output | 16 | Data driven toward the memory |
| mem_dq_oe | output | 1 | Data-bus driver enable |
| mem_dq_i | input | 16 | Data bus as seen from the memory |

## Verification
Two things can meet in the same cycle. One is a read finishing and releasing output enable. The other is a new write being accepted and wanting to drive the shared data bus. The bench provokes this by presenting a write in the very cycle that ready returns after a read. Its memory model tracks how many cycles output enable has been high, and it reports any cycle where the controller drives the bus while the memory may still be driving it. It also measures the added turnaround cycles through the ready handshake and reads the written word back.

// File: rtl/sram_async_ctrl.sv
module sram_async_ctrl #(
  parameter int CLK_NS  = 10,
  parameter int AW      = 19,
  parameter int T_RC    = 70,
  parameter int T_AA    = 70,
  parameter int T_DOE   = 35,
  parameter int T_WC    = 70,
  parameter int T_WP    = 50,
  parameter int T_DS    = 30,
  parameter int T_HZOE  = 25
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic          req_write,
  input  logic [AW-1:0] req_addr,
  input  logic [15:0]   req_wdata,
  input  logic [1:0]    req_bmask,
  output logic [15:0]   rsp_rdata,
  output logic          rsp_valid,
  output logic          mem_ce1_n,
  output logic          mem_ce2,
  output logic          mem_we_n,
  output logic          mem_oe_n,
  output logic          mem_ub_n,
  output logic          mem_lb_n,
  output logic [AW-1:0] mem_addr,
  output logic [15:0]   mem_dq_o,
  output logic          mem_dq_oe,
  input  logic [15:0]   mem_dq_i
);

  function automatic int cyc(input int ns);
    int r;
    r = (ns + CLK_NS - 1) / CLK_NS;
    return (r < 1) ? 1 : r;
  endfunction

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  localparam int N_RD  = imax(imax(cyc(T_RC), cyc(T_AA)), cyc(T_DOE));
  localparam int N_WP  = imax(cyc(T_WP), cyc(T_DS));
  localparam int N_WC  = cyc(T_WC);
  localparam int N_REC = (N_WC > N_WP) ? N_WC - N_WP : 0;
  localparam int N_HZ  = cyc(T_HZOE);
  localparam int CW    = $clog2(imax(N_RD, imax(N_WP, N_REC)) + 1) + 1;
  localparam int HW    = $clog2(N_HZ + 1) + 1;

  typedef enum logic [2:0] {S_IDLE, S_RD, S_TURN, S_WP, S_REC} st_t;

  st_t           st;
  logic [CW-1:0] cnt;
  logic [HW-1:0] hz;
  logic [1:0]    lanes;

  assign req_ready = (st == S_IDLE);
  wire accept  = req_valid && req_ready;
  wire turn_ok = mem_oe_n && (hz >= HW'(N_HZ - 1));
  wire [15:0] lane_mask = {{8{lanes[1]}}, {8{lanes[0]}}};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hz <= HW'(N_HZ);
    else if (!mem_oe_n) hz <= '0;
    else if (hz != HW'(N_HZ)) hz <= hz + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; cnt <= '0; lanes <= '0;
      mem_ce1_n <= 1'b1; mem_ce2 <= 1'b0; mem_we_n <= 1'b1; mem_oe_n <= 1'b1;
      mem_ub_n <= 1'b1; mem_lb_n <= 1'b1; mem_dq_oe <= 1'b0;
      mem_addr <= '0; mem_dq_o <= '0; rsp_rdata <= '0; rsp_valid <= 1'b0;
    end else begin
      rsp_valid <= 1'b0;
      case (st)
        S_IDLE: if (accept) begin
          mem_addr  <= req_addr;
          lanes     <= req_bmask;
          mem_ce1_n <= 1'b0;
          mem_ce2   <= 1'b1;
          mem_ub_n  <= ~req_bmask[1];
          mem_lb_n  <= ~req_bmask[0];
          cnt       <= CW'(1);
          if (!req_write) begin
            st <= S_RD; mem_oe_n <= 1'b0;
          end else begin
            mem_dq_o <= req_wdata;
            if (turn_ok) begin
              st <= S_WP; mem_we_n <= 1'b0; mem_dq_oe <= 1'b1;
            end else st <= S_TURN;
          end
        end
        S_RD: if (cnt == CW'(N_RD)) begin
          rsp_rdata <= mem_dq_i & lane_mask;
          rsp_valid <= 1'b1;
          st <= S_IDLE;
          mem_oe_n <= 1'b1; mem_ce1_n <= 1'b1; mem_ce2 <= 1'b0;
          mem_ub_n <= 1'b1; mem_lb_n <= 1'b1;
        end else cnt <= cnt + 1'b1;
        S_TURN: if (turn_ok) begin
          st <= S_WP; mem_we_n <= 1'b0; mem_dq_oe <= 1'b1;
        end
        S_WP: if (cnt == CW'(N_WP)) begin
          mem_we_n <= 1'b1; mem_dq_oe <= 1'b0; cnt <= CW'(1);
          if (N_REC == 0) begin
            st <= S_IDLE; mem_ce1_n <= 1'b1; mem_ce2 <= 1'b0;
            mem_ub_n <= 1'b1; mem_lb_n <= 1'b1;
          end else st <= S_REC;
        end else cnt <= cnt + 1'b1;
        S_REC: if (cnt >= CW'(N_REC)) begin
          st <= S_IDLE; mem_ce1_n <= 1'b1; mem_ce2 <= 1'b0;
          mem_ub_n <= 1'b1; mem_lb_n <= 1'b1;
        end else cnt <= cnt + 1'b1;
        default: st <= S_IDLE;
      endcase
    end
  end

  logic [CW-1:0] we_lo;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) we_lo <= '0;
    else if (!mem_we_n) we_lo <= we_lo + 1'b1;
    else we_lo <= '0;
  end

  a_r1_idle_pins: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (mem_ce1_n && !mem_ce2 && mem_we_n && mem_oe_n && mem_ub_n && mem_lb_n && !mem_dq_oe));
  a_r2_valid_single: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);
  a_r3_pulse_width: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_we_n) |-> (we_lo == CW'(N_WP)));
  a_r7_float_wait: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_dq_oe) |-> (mem_oe_n && hz == HW'(N_HZ)));
  a_r8_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
    !(!mem_we_n && !mem_oe_n));
  a_r8_bus_with_we: assert property (@(posedge clk) disable iff (!rst_n)
    mem_dq_oe == !mem_we_n);
  a_r9_stable_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_we_n && $past(!mem_we_n)) |-> ($stable(mem_addr) && $stable(mem_dq_o) && $stable(mem_ub_n) && $stable(mem_lb_n)));
  a_r10_ready_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && req_write) |=> !req_ready);

endmodule

// File: tb/tb_sram_async_ctrl.sv
module tb_sram_async_ctrl;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [18:0] req_addr = '0;
  logic [15:0] req_wdata = '0;
  logic [1:0]  req_bmask = '0;
  logic req_ready, rsp_valid;
  logic [15:0] rsp_rdata;
  logic mem_ce1_n, mem_ce2, mem_we_n, mem_oe_n, mem_ub_n, mem_lb_n, mem_dq_oe;
  logic [18:0] mem_addr;
  logic [15:0] mem_dq_o, mem_dq_i;

  int total = 0, bad = 0, cycles = 0;

  always #5 clk = ~clk;

  sram_async_ctrl dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .req_bmask(req_bmask), .rsp_rdata(rsp_rdata), .rsp_valid(rsp_valid),
    .mem_ce1_n(mem_ce1_n), .mem_ce2(mem_ce2), .mem_we_n(mem_we_n),
    .mem_oe_n(mem_oe_n), .mem_ub_n(mem_ub_n), .mem_lb_n(mem_lb_n),
    .mem_addr(mem_addr), .mem_dq_o(mem_dq_o), .mem_dq_oe(mem_dq_oe),
    .mem_dq_i(mem_dq_i)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // memory model
  logic [15:0] mdl [0:255];
  logic [15:0] ex  [0:255];
  int acc = 0, oel = 0, oeh = 0, wcnt = 0, dstab = 0;
  logic p_wlow = 1'b0, p_dqoe = 1'b0, p_ub = 1'b1, p_lb = 1'b1;
  logic [18:0] p_addr = '0, last_addr = '0;
  logic [15:0] p_dq = '0;

  always @(negedge clk) begin
    bit sel, rdm, wlow;
    int nd;
    if (rst_n) begin
      sel  = !mem_ce1_n && mem_ce2;
      rdm  = sel && mem_we_n && !mem_oe_n;
      acc  = rdm ? ((mem_addr == last_addr && acc > 0) ? acc + 1 : 1) : 0;
      last_addr = mem_addr;
      oel  = !mem_oe_n ? oel + 1 : 0;
      oeh  = mem_oe_n ? ((oeh < 100) ? oeh + 1 : oeh) : 0;
      if (mem_dq_oe) chk(oeh >= 4, "R7 bus driven during memory float time", oeh, 4);
      if (!mem_we_n || mem_dq_oe) begin
        chk(mem_oe_n, "R8 oe low during write", mem_oe_n, 1);
        chk(mem_dq_oe == !mem_we_n, "R8 bus enable vs write enable", mem_dq_oe, !mem_we_n);
      end
      wlow = sel && !mem_we_n && (!mem_ub_n || !mem_lb_n);
      if (wlow && p_wlow)
        chk(mem_addr == p_addr && mem_dq_o == p_dq && mem_ub_n == p_ub && mem_lb_n == p_lb,
            "R9 pins moved during write pulse", int'(mem_addr), int'(p_addr));
      if (p_wlow && !wlow) begin
        chk(wcnt >= 5, "R3 write pulse cycles", wcnt, 5);
        chk(dstab >= 3, "R3 data setup cycles", dstab, 3);
        if (!p_lb) mdl[p_addr[7:0]][7:0]  = p_dq[7:0];
        if (!p_ub) mdl[p_addr[7:0]][15:8] = p_dq[15:8];
      end
      nd    = mem_dq_oe ? ((p_dqoe && mem_dq_o == p_dq) ? dstab + 1 : 1) : 0;
      wcnt  = wlow ? wcnt + 1 : 0;
      dstab = nd;
      p_wlow = wlow; p_dqoe = mem_dq_oe; p_addr = mem_addr; p_dq = mem_dq_o;
      p_ub = mem_ub_n; p_lb = mem_lb_n;
    end
  end

  always_comb begin
    if (!(!mem_ce1_n && mem_ce2 && mem_we_n && !mem_oe_n)) mem_dq_i = 16'hBEEF;
    else if (acc < 7 || oel < 4) mem_dq_i = 16'hDEAD;
    else mem_dq_i = {mem_ub_n ? 8'hEE : mdl[mem_addr[7:0]][15:8],
                     mem_lb_n ? 8'hEE : mdl[mem_addr[7:0]][7:0]};
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      bad++; total++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 20000);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  // called at a negedge, returns at the negedge where ready is back
  task automatic do_req(input bit wr, input logic [18:0] a, input logic [15:0] d,
                        input logic [1:0] m, output logic [15:0] rd,
                        output int busy, output bit got);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d; req_bmask = m;
    while (!req_ready) @(negedge clk);
    @(posedge clk); #1 req_valid = 1'b0;
    busy = 0;
    @(negedge clk);
    while (!req_ready) begin busy++; @(negedge clk); end
    got = rsp_valid; rd = rsp_rdata;
    if (wr) begin
      if (m[0]) ex[a[7:0]][7:0]  = d[7:0];
      if (m[1]) ex[a[7:0]][15:8] = d[15:8];
    end
  endtask

  task automatic t_reset;
    chk(mem_ce1_n && !mem_ce2 && mem_we_n && mem_oe_n && mem_ub_n && mem_lb_n && !mem_dq_oe,
        "R1 idle pins after reset", {mem_ce1_n, mem_ce2, mem_we_n, mem_oe_n, mem_dq_oe}, 5'b10110);
    chk(req_ready && !rsp_valid, "R10 ready after reset", {req_ready, rsp_valid}, 2'b10);
  endtask

  task automatic t_write_read;
    logic [15:0] rd; int busy; bit got;
    do_req(1, 19'h10, 16'h5AC3, 2'b11, rd, busy, got);
    chk(busy == 7, "R4 write cycle length", busy, 7);
    chk(!got, "R2 no valid on write", got, 0);
    chk(mem_ce1_n && !mem_ce2 && mem_we_n && mem_oe_n, "R1 idle after write", mem_ce1_n, 1);
    do_req(0, 19'h10, 16'h0, 2'b11, rd, busy, got);
    chk(busy == 7, "R2 read length", busy, 7);
    chk(got, "R2 valid in 8th cycle", got, 1);
    chk(rd == 16'h5AC3, "R2 read data", rd, 16'h5AC3);
    @(negedge clk);
    chk(!rsp_valid, "R2 valid one cycle", rsp_valid, 0);
  endtask

  task automatic t_bytes;
    logic [15:0] rd; int busy; bit got;
    do_req(1, 19'h20, 16'hFFFF, 2'b11, rd, busy, got);
    do_req(1, 19'h20, 16'h1234, 2'b01, rd, busy, got);
    do_req(0, 19'h20, 16'h0, 2'b11, rd, busy, got);
    chk(rd == 16'hFF34, "R5 low lane only", rd, 16'hFF34);
    do_req(1, 19'h20, 16'hAB00, 2'b10, rd, busy, got);
    do_req(0, 19'h20, 16'h0, 2'b11, rd, busy, got);
    chk(rd == 16'hAB34, "R5 high lane only", rd, 16'hAB34);
    do_req(1, 19'h20, 16'h0000, 2'b00, rd, busy, got);
    do_req(0, 19'h20, 16'h0, 2'b11, rd, busy, got);
    chk(rd == 16'hAB34, "R5 empty mask writes nothing", rd, 16'hAB34);
  endtask

  task automatic t_read_mask;
    logic [15:0] rd; int busy; bit got;
    do_req(0, 19'h20, 16'h0, 2'b01, rd, busy, got);
    chk(rd == 16'h0034, "R6 read low lane", rd, 16'h0034);
    do_req(0, 19'h20, 16'h0, 2'b10, rd, busy, got);
    chk(rd == 16'hAB00, "R6 read high lane", rd, 16'hAB00);
    do_req(0, 19'h20, 16'h0, 2'b00, rd, busy, got);
    chk(rd == 16'h0000 && got, "R6 read no lane", rd, 0);
  endtask

  task automatic t_turnaround;
    logic [15:0] rd; int busy; bit got;
    do_req(0, 19'h10, 16'h0, 2'b11, rd, busy, got);
    do_req(1, 19'h30, 16'hC0DE, 2'b11, rd, busy, got);
    chk(busy == 9, "R7 write after read waits float time", busy, 9);
    do_req(1, 19'h31, 16'h7E57, 2'b11, rd, busy, got);
    chk(busy == 7, "R4 write after write no turnaround", busy, 7);
    do_req(0, 19'h30, 16'h0, 2'b11, rd, busy, got);
    chk(rd == 16'hC0DE, "R7 turnaround write data", rd, 16'hC0DE);
  endtask

  task automatic t_sweep;
    logic [15:0] rd; int busy; bit got;
    for (int i = 0; i < 16; i++)
      do_req(1, 19'(i * 7 + 64), 16'(i * 16'h1357 + 16'h0F0F), 2'(i % 4), rd, busy, got);
    for (int i = 0; i < 16; i++) begin
      do_req(0, 19'(i * 7 + 64), 16'h0, 2'b11, rd, busy, got);
      chk(rd == ex[8'(i * 7 + 64)], "R5 sweep readback", rd, ex[8'(i * 7 + 64)]);
    end
  endtask

  initial begin
    for (int i = 0; i < 256; i++) begin mdl[i] = 16'h0; ex[i] = 16'h0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_reset;
    t_write_read;
    t_bytes;
    t_read_mask;
    t_turnaround;
    t_sweep;
    repeat (4) @(negedge clk);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule